// File: doc/BRIEF.md
# Integer Multiply-Accumulate Lane with Doubled Saturating Extraction

This block is one multiply-accumulate lane for a signed 16-bit datapath. Each accepted operation picks one 16-bit half from each of two 32-bit source words. It forms their signed integer product and then loads, adds or subtracts that product into a 40-bit accumulator.

From the updated accumulator the lane produces a 16-bit result: it doubles the value and saturates it to the signed 16-bit range. That result replaces the low half of a destination word, and the upper half of the destination passes through unchanged. The low 32 bits of the accumulator are always visible as a readout word.

The lane is driven by an upstream decoder. The decoder presents the source words, half selects, opcode and old destination word with a one-cycle valid strobe. It then collects the new destination word and the accumulator word one cycle later. A separate clear input zeroes the accumulator.

Top module: `imac_sat_lane`

## Requirements
- R1: `hi_a_i`/`hi_b_i` equal to 1 select bits [31:16] of `src_a_i`/`src_b_i` as the operand; 0 selects bits [15:0]. The two selects are independent.
- R2: The product is the plain signed two's-complement product of the two 16-bit operands, with no left shift. Opcode 2'b00 (load) sets the accumulator to that product, sign-extended. For example, 0xFEC7 times 0x5ABD gives an accumulator readout of 0xFF910EEB.
- R3: Opcode 2'b01 adds the sign-extended product to the accumulator. Opcode 2'b10 subtracts it. Opcode 2'b11 behaves as a load.
- R4: The accumulator is 40 bits wide and wraps modulo 2^40 on add and subtract. `acc_o` shows its bits [31:0].
- R5: `dest_o[15:0]` is twice the updated accumulator, clamped to the signed 16-bit range. A value above 32767 gives 0x7FFF and a value below -32768 gives 0x8000. Because a doubled integer has no fractional part, rounding never changes it.
- R6: `dest_o[31:16]` equals `dest_i[31:16]` of the operation that produced the result.
- R7: An operation accepted with `vld_i` high updates `acc_o` and `dest_o` at the next rising edge. At that same edge `res_vld_o` is high for one cycle. With no operation, `acc_o` and `dest_o` hold.
- R8: `clr_i` sets the accumulator to zero at the next edge. An operation presented in the same cycle as `clr_i` is dropped: `res_vld_o` stays low and `dest_o` holds.
- R9: Synchronous reset `rst` sets the accumulator, `dest_o` and `res_vld_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Zero the accumulator; wins over `vld_i` |
| vld_i | input | 1 | Operation strobe |
| op_i | input | 2 | 00 load, 01 add, 10 subtract, 11 load |
| src_a_i | input | 32 | First source word |
| src_b_i | input | 32 | Second source word |
| hi_a_i | input | 1 | Take the upper half of `src_a_i` |
| hi_b_i | input | 1 | Take the upper half of `src_b_i` |
| dest_i | input | 32 | Previous destination word |
| dest_o | output | 32 | Destination word with new low half |
| acc_o | output | 32 | Accumulator bits [31:0] |
| res_vld_o | output | 1 | Result strobe, one cycle after `vld_i` |

## Verification
The bench builds the lane with its default parameters: 16-bit halves and a 40-bit accumulator. With these widths the largest product, 0x8000 times 0x8000 = 2^30, reaches 2^38 after 256 additions and wraps to -2^39 after 512. The positive clamp, the negative clamp and the 40-bit wrap therefore all fall within a short run. Values that come close to the clamp from both sides, and in-range values, check the exact edges of the saturation window.

// File: rtl/imac_pkg.sv
package imac_pkg;

    // Default widths shared by the lane and its bench.
    localparam int DEF_HALF_W = 16;
    localparam int DEF_ACC_W  = 40;

    // Accumulate opcode. Code 2'b11 is handled as a load.
    typedef enum logic [1:0] {
        ACC_LOAD = 2'b00,
        ACC_ADD  = 2'b01,
        ACC_SUB  = 2'b10,
        ACC_ALT  = 2'b11
    } acc_op_e;

    // Operand selector for one multiplier input.
    typedef enum logic {
        PICK_LO = 1'b0,
        PICK_HI = 1'b1
    } half_pick_e;

endpackage

// File: rtl/imac_half_pick.sv
module imac_half_pick
    import imac_pkg::*;
#(
    parameter int HALF_W = DEF_HALF_W,
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic [WORD_W-1:0] word_i,
    input  half_pick_e        pick_i,
    output logic [HALF_W-1:0] half_o
);

    always_comb begin
        unique case (pick_i)
            PICK_HI: half_o = word_i[WORD_W-1:HALF_W];
            default: half_o = word_i[HALF_W-1:0];
        endcase
    end

endmodule

// File: rtl/imac_acc_reg.sv
module imac_acc_reg
    import imac_pkg::*;
#(
    parameter int ACC_W  = DEF_ACC_W,
    parameter int PROD_W = 2 * DEF_HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic              vld_i,
    input  acc_op_e           op_i,
    input  logic [PROD_W-1:0] prod_i,
    output logic [ACC_W-1:0]  acc_nxt_o,
    output logic [ACC_W-1:0]  acc_q_o
);

    localparam int EXT_W = ACC_W - PROD_W;

    logic [ACC_W-1:0] prod_ext;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_nxt;

    assign prod_ext = {{EXT_W{prod_i[PROD_W-1]}}, prod_i};

    // Add and subtract wrap within ACC_W bits; the accumulator never clamps.
    always_comb begin
        acc_nxt = acc_q;
        if (clr_i) begin
            acc_nxt = '0;
        end else if (vld_i) begin
            unique case (op_i)
                ACC_ADD: acc_nxt = acc_q + prod_ext;
                ACC_SUB: acc_nxt = acc_q - prod_ext;
                default: acc_nxt = prod_ext;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_nxt;
    end

    assign acc_nxt_o = acc_nxt;
    assign acc_q_o   = acc_q;

    p_clear_zero_r8: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (acc_q == '0));

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !vld_i) |=> $stable(acc_q));

    p_load_product_r2: assert property (@(posedge clk) disable iff (rst)
        (vld_i && !clr_i && op_i == ACC_LOAD) |=> (acc_q == $past(prod_ext)));

endmodule

// File: rtl/imac_sat_extract.sv
module imac_sat_extract
    import imac_pkg::*;
#(
    parameter int ACC_W  = DEF_ACC_W,
    parameter int HALF_W = DEF_HALF_W
) (
    input  logic [ACC_W-1:0]  acc_i,
    output logic [HALF_W-1:0] half_o
);

    localparam int DBL_W = ACC_W + 1;
    localparam int TOP_W = DBL_W - HALF_W + 1;

    // Doubling is a one-place shift. The doubled integer has no bits below
    // its LSB, so the half-LSB rounding step adds nothing here.
    logic [DBL_W-1:0] dbl;
    logic [TOP_W-1:0] top_bits;
    logic             fits;

    assign dbl      = {acc_i, 1'b0};
    assign top_bits = dbl[DBL_W-1:HALF_W-1];
    assign fits     = (&top_bits) | ~(|top_bits);

    always_comb begin
        if (fits)
            half_o = dbl[HALF_W-1:0];
        else if (dbl[DBL_W-1])
            half_o = {1'b1, {(HALF_W-1){1'b0}}};
        else
            half_o = {1'b0, {(HALF_W-1){1'b1}}};
    end

    // The sign of the clamped result always follows the accumulator sign.
    always_comb begin
        p_sign_follow_r5: assert (half_o[HALF_W-1] == acc_i[ACC_W-1]);
    end

endmodule

// File: rtl/imac_sat_lane.sv
module imac_sat_lane
    import imac_pkg::*;
#(
    parameter int HALF_W = DEF_HALF_W,
    parameter int ACC_W  = DEF_ACC_W,
    localparam int WORD_W = 2 * HALF_W,
    localparam int PROD_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic              vld_i,
    input  logic [1:0]        op_i,
    input  logic [WORD_W-1:0] src_a_i,
    input  logic [WORD_W-1:0] src_b_i,
    input  logic              hi_a_i,
    input  logic              hi_b_i,
    input  logic [WORD_W-1:0] dest_i,
    output logic [WORD_W-1:0] dest_o,
    output logic [WORD_W-1:0] acc_o,
    output logic              res_vld_o
);

    logic [WORD_W-1:0] src_w  [2];
    half_pick_e        pick_w [2];
    logic [HALF_W-1:0] opnd   [2];

    assign src_w[0]  = src_a_i;
    assign src_w[1]  = src_b_i;
    assign pick_w[0] = half_pick_e'(hi_a_i);
    assign pick_w[1] = half_pick_e'(hi_b_i);

    for (genvar g = 0; g < 2; g++) begin : g_opnd
        imac_half_pick #(.HALF_W(HALF_W)) i_pick (
            .word_i (src_w[g]),
            .pick_i (pick_w[g]),
            .half_o (opnd[g])
        );
    end

    // Signed integer product, sign-extended to full width before multiplying.
    logic signed [PROD_W-1:0] mul_a, mul_b, prod;
    assign mul_a = $signed({{HALF_W{opnd[0][HALF_W-1]}}, opnd[0]});
    assign mul_b = $signed({{HALF_W{opnd[1][HALF_W-1]}}, opnd[1]});
    assign prod  = mul_a * mul_b;

    logic [ACC_W-1:0] acc_nxt, acc_q;

    imac_acc_reg #(.ACC_W(ACC_W), .PROD_W(PROD_W)) i_acc (
        .clk       (clk),
        .rst       (rst),
        .clr_i     (clr_i),
        .vld_i     (vld_i),
        .op_i      (acc_op_e'(op_i)),
        .prod_i    (prod),
        .acc_nxt_o (acc_nxt),
        .acc_q_o   (acc_q)
    );

    logic [HALF_W-1:0] sat_half;

    imac_sat_extract #(.ACC_W(ACC_W), .HALF_W(HALF_W)) i_ext (
        .acc_i  (acc_nxt),
        .half_o (sat_half)
    );

    logic take;
    assign take = vld_i & ~clr_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            dest_o    <= '0;
            res_vld_o <= 1'b0;
        end else begin
            res_vld_o <= take;
            if (take) dest_o <= {dest_i[WORD_W-1:HALF_W], sat_half};
        end
    end

    assign acc_o = acc_q[WORD_W-1:0];

    p_upper_kept_r6: assert property (@(posedge clk) disable iff (rst)
        res_vld_o |-> (dest_o[WORD_W-1:HALF_W] == $past(dest_i[WORD_W-1:HALF_W])));

    p_one_cycle_r7: assert property (@(posedge clk) disable iff (rst)
        (vld_i && !clr_i) |=> res_vld_o);

    p_dest_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !(vld_i && !clr_i) |=> ($stable(dest_o) && !res_vld_o));

    p_sign_match_r5: assert property (@(posedge clk) disable iff (rst)
        res_vld_o |-> (dest_o[HALF_W-1] == acc_q[ACC_W-1]));

endmodule

// File: tb/test_imac_sat_lane.sv
module test_imac_sat_lane;
    import imac_pkg::*;

    localparam int HW = DEF_HALF_W;
    localparam int AW = DEF_ACC_W;
    localparam int WW = 2 * HW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clr_i = 1'b0;
    logic          vld_i = 1'b0;
    logic [1:0]    op_i = 2'b00;
    logic [WW-1:0] src_a_i = '0, src_b_i = '0, dest_i = '0;
    logic          hi_a_i = 1'b0, hi_b_i = 1'b0;
    logic [WW-1:0] dest_o, acc_o;
    logic          res_vld_o;

    always #2.5 clk = ~clk;

    imac_sat_lane i_imac_sat_lane (
        .clk(clk), .rst(rst), .clr_i(clr_i), .vld_i(vld_i), .op_i(op_i),
        .src_a_i(src_a_i), .src_b_i(src_b_i), .hi_a_i(hi_a_i), .hi_b_i(hi_b_i),
        .dest_i(dest_i), .dest_o(dest_o), .acc_o(acc_o), .res_vld_o(res_vld_o)
    );

    typedef struct {
        logic [WW-1:0] acc;
        logic [WW-1:0] dest;
        string         req;
    } exp_t;

    exp_t           sb[$];
    int             errors = 0;
    int             checks = 0;
    logic signed [AW-1:0] m_acc = '0;
    logic [WW-1:0]  last_dest = '0;

    task automatic check32(string req, logic [WW-1:0] act, logic [WW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [HW-1:0] m_sat(logic signed [AW-1:0] a);
        logic signed [AW:0] d;
        d = {a, 1'b0};
        if (d > 41'sd32767)       return 16'h7FFF;
        else if (d < -41'sd32768) return 16'h8000;
        else                      return d[HW-1:0];
    endfunction

    // Driver: apply one operation and push its expected result.
    task automatic do_op(logic [WW-1:0] a, logic [WW-1:0] b, logic ha, logic hb,
                         logic [1:0] op, logic [WW-1:0] d, string req);
        logic signed [HW-1:0] oa, ob;
        logic signed [AW-1:0] p;
        exp_t e;
        @(negedge clk);
        src_a_i = a; src_b_i = b; hi_a_i = ha; hi_b_i = hb;
        op_i = op; dest_i = d; vld_i = 1'b1;
        oa = ha ? a[WW-1:HW] : a[HW-1:0];
        ob = hb ? b[WW-1:HW] : b[HW-1:0];
        p  = AW'(oa) * AW'(ob);
        case (op)
            2'b01:   m_acc = m_acc + p;
            2'b10:   m_acc = m_acc - p;
            default: m_acc = p;
        endcase
        e.acc  = m_acc[WW-1:0];
        e.dest = {d[WW-1:HW], m_sat(m_acc)};
        e.req  = req;
        sb.push_back(e);
        last_dest = e.dest;
        @(negedge clk);
        vld_i = 1'b0;
    endtask

    // Monitor: pop and compare as results appear.
    always @(negedge clk) begin
        if (!rst && res_vld_o) begin
            if (sb.size() == 0) begin
                checks++; errors++;
                $display("FAIL R7 actual=unexpected result expected=none");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check32({e.req, " acc"},  acc_o,  e.acc);
                check32({e.req, " dest"}, dest_o, e.dest);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check32("R9 acc",  acc_o,  '0);
        check32("R9 dest", dest_o, '0);
        check32("R9 vld",  {31'd0, res_vld_o}, '0);

        // R2 load: low halves, 0xFEC7 * 0x5ABD
        do_op(32'h7fbcfec7, 32'hf3545abd, 0, 0, 2'b00, 32'hf3541111, "R2");
        // R1 select mixes, R3 subtract and add
        do_op(32'hc7fff679, 32'hd0799007, 1, 0, 2'b10, 32'hc7ff0000, "R1 R3 sub");
        do_op(32'hefb79f69, 32'hcd35700b, 1, 1, 2'b01, 32'hefb70000, "R1 R3 add");
        do_op(32'he00c87fd, 32'hf78e909f, 0, 1, 2'b01, 32'he00c0000, "R1 R3 add2");
        // R5 positive clamp: 0xCFB9 * 0x9B5C large positive
        do_op(32'hcfb9b5c9, 32'h52359b5c, 1, 0, 2'b00, 32'habcd0000, "R5 pos");
        // R3 opcode 11 acts as load
        do_op(32'h00000003, 32'h00000005, 0, 0, 2'b11, 32'h12340000, "R3 alt");
        // R5 in-range and edges of the clamp window
        do_op(32'h00003fff, 32'h00000001, 0, 0, 2'b00, 32'h5a5a0000, "R5 max in");
        do_op(32'h00004000, 32'h00000001, 0, 0, 2'b00, 32'h5a5a0000, "R5 just over");
        do_op(32'h0000c000, 32'h00000001, 0, 0, 2'b00, 32'h5a5a0000, "R5 min in");
        do_op(32'h0000bfff, 32'h00000001, 0, 0, 2'b00, 32'h5a5a0000, "R5 just under");
        do_op(32'h0000ffff, 32'h00000001, 0, 0, 2'b00, 32'h5a5a0000, "R5 minus one");

        // R7 hold when idle
        repeat (3) @(negedge clk);
        check32("R7 dest hold", dest_o, last_dest);
        check32("R7 acc hold",  acc_o,  m_acc[WW-1:0]);

        // R8 clear, then clear with a colliding operation
        @(negedge clk); clr_i = 1'b1; m_acc = '0;
        @(negedge clk); clr_i = 1'b0;
        check32("R8 clear", acc_o, '0);
        @(negedge clk);
        clr_i = 1'b1; vld_i = 1'b1; op_i = 2'b00;
        src_a_i = 32'h00007000; src_b_i = 32'h00007000; dest_i = 32'hffffffff;
        @(negedge clk); clr_i = 1'b0; vld_i = 1'b0;
        check32("R8 dropped vld",  {31'd0, res_vld_o}, '0);
        check32("R8 dropped acc",  acc_o, '0);
        check32("R8 dropped dest", dest_o, last_dest);

        // R4 wrap: 0x8000*0x8000 = 2^30, add 256 then 512 times
        for (int i = 0; i < 512; i++) begin
            do_op(32'h00008000, 32'h00008000, 0, 0, (i == 0) ? 2'b00 : 2'b01,
                  32'h77770000, (i == 255) ? "R4 2^38" : (i == 511) ? "R4 wrap" : "R4");
        end
        // R4 subtract back across the wrap
        do_op(32'h00008000, 32'h00008000, 0, 0, 2'b10, 32'h77770000, "R4 sub wrap");

        repeat (3) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R7 actual=%0d pending expected=0", sb.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule